// File: doc/BRIEF.md
# Paced Serial Transmit Queue

This block buffers bytes written by a processor on their way to the transmit shift register of a serial port. A single write holding register takes each written byte. In queue mode that byte moves into a 16-entry first-in first-out store. The store then releases words to the shifter one at a time. After each release, a programmable gap, measured in baud ticks, must pass before the next word can go. A gap of zero lets words leave back to back.

The block reports how many words it holds and raises an interrupt request while that count is at or below a programmable level. Software can empty the store at any time by dropping a run control. With queue mode off, which is the state after reset, the holding register feeds the shifter directly. The serial shifter, baud generation and register decoding sit outside the block.

Top module: `txq_pacer`

## Requirements
- R1: After reset, `fill` is 0, `shf_load` is low and `irq` is low, with queue mode off (`q_en` low).
- R2: With `q_en` low, a written byte is offered to the shifter (`shf_load` high, `shf_data` equal to the byte) in the cycles after the write edge where `shf_idle` is high. It stays held while `shf_idle` is low and is offered exactly once.
- R3: With `q_en` and `q_run` high, the held byte enters the store only in a cycle where `shf_idle` is high, which means the last bit of the shifter has gone out. Each accepted byte raises `fill` by one.
- R4: Words leave the store in the order they were written, and `shf_data` carries the oldest stored word whenever `shf_load` is high in queue mode.
- R5: The store holds at most 16 words. A byte that would enter while `fill` is 16 is discarded, and `fill` stays at 16.
- R6: In queue mode, every load to the shifter reloads the gap counter with `gap_cfg`. The counter drops by one on each `baud_tick`. The next load needs the counter at zero and `shf_idle` high. With a tick every cycle, successive loads are `gap_cfg`+1 cycles apart: 1 for a gap of 0, 2 for a gap of 1, 256 for a gap of 255.
- R7: Without `baud_tick`, a non-zero gap counter holds its value, and no further word is loaded.
- R8: While `q_run` is low, the pointers, `fill` and the gap counter are cleared at each clock edge. After `q_run` returns high, the next written byte is the first one loaded, with no wait.
- R9: `irq` is high exactly when `q_en` is high and `fill` <= `trig_lvl` (both unsigned, 5 bits).
- R10: When a byte enters the store in the same cycle a word leaves it, `fill` is unchanged, and the word that leaves is the older head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| q_en | input | 1 | Queue mode enable (0 = direct path) |
| q_run | input | 1 | Run control; low empties the store |
| gap_cfg | input | 8 | Gap between loads, in baud ticks |
| trig_lvl | input | 5 | Interrupt level for the fill comparison |
| wr_stb | input | 1 | Write strobe into the holding register |
| wr_data | input | 8 | Byte written |
| baud_tick | input | 1 | One-cycle baud clock pulse |
| shf_idle | input | 1 | Shifter has sent its last bit |
| shf_load | output | 1 | Load strobe to the shifter |
| shf_data | output | 8 | Word offered to the shifter |
| fill | output | 5 | Words currently stored (0..16) |
| irq | output | 1 | Fill-level interrupt request |

## Verification
A push into the store and a pop to the shifter can fall in the same cycle, because both wait on `shf_idle`. The bench sets this up by holding two words with a drained gap counter and a byte waiting in the holding register while `shf_idle` is low. It then raises `shf_idle` for exactly one edge. It checks that the load carries the older head word, that `fill` is unchanged afterwards, and that the later words still leave in write order.

// File: rtl/txq_pkg.sv
package txq_pkg;

  // Occupancy after one cycle of push/pop activity.
  function automatic int fill_after(input int cur, input bit push, input bit pop);
    return cur + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

  // Threshold comparison for the interrupt request.
  function automatic bit level_hit(input int cur_fill, input int lvl);
    return cur_fill <= lvl;
  endfunction

endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [DW-1:0]                wdata,
  input  logic                         pop,
  output logic [DW-1:0]                rdata,
  output logic [$clog2(DEPTH+1)-1:0]   fill
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      cnt <= CW'(txq_pkg::fill_after(int'(cnt), push, pop));
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wp] <= wdata;
  end

  assign rdata = mem[rp];
  assign fill  = cnt;
endmodule

// File: rtl/txq_gap.sv
module txq_gap #(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [GW-1:0] cfg,
  input  logic          tick,
  output logic          done
);
  logic [GW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr)                 cnt <= '0;
    else if (load)                cnt <= cfg;
    else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/txq_pacer.sv
module txq_pacer #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int GW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_en,
  input  logic          q_run,
  input  logic [GW-1:0] gap_cfg,
  input  logic [CW-1:0] trig_lvl,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          baud_tick,
  input  logic          shf_idle,
  output logic          shf_load,
  output logic [DW-1:0] shf_data,
  output logic [CW-1:0] fill,
  output logic          irq
);
  // holding register
  logic [DW-1:0] hold_q;
  logic          hold_v;

  // named events
  logic q_act, mv_evt, push_evt, pop_evt, byp_evt, full, gap_done;
  logic [DW-1:0] head;

  assign q_act    = q_en & q_run;
  assign full     = (fill == CW'(DEPTH));
  assign mv_evt   = q_act & hold_v & shf_idle;
  assign push_evt = mv_evt & ~full;
  assign pop_evt  = q_act & shf_idle & (fill != '0) & gap_done;
  assign byp_evt  = ~q_en & hold_v & shf_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      hold_v <= 1'b0;
    end else if (wr_stb) begin
      hold_q <= wr_data;
      hold_v <= 1'b1;
    end else if (mv_evt || byp_evt) begin
      hold_v <= 1'b0;
    end
  end

  txq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (~q_run),
    .push  (push_evt),
    .wdata (hold_q),
    .pop   (pop_evt),
    .rdata (head),
    .fill  (fill)
  );

  txq_gap #(.GW(GW)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (~q_run),
    .load  (pop_evt),
    .cfg   (gap_cfg),
    .tick  (baud_tick),
    .done  (gap_done)
  );

  assign shf_load = pop_evt | byp_evt;
  assign shf_data = q_en ? head : hold_q;
  assign irq      = q_en & txq_pkg::level_hit(int'(fill), int'(trig_lvl));
endmodule

// File: rtl/txq_pacer_chk.sv
module txq_pacer_chk #(
  parameter int DEPTH = 16,
  parameter int GW    = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       q_en,
  input logic                       q_run,
  input logic                       baud_tick,
  input logic                       shf_idle,
  input logic                       shf_load,
  input logic                       irq,
  input logic [$clog2(DEPTH+1)-1:0] fill,
  input logic [GW-1:0]              gap_cfg,
  input logic                       push_evt,
  input logic                       pop_evt,
  input logic                       gap_done
);
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= ($clog2(DEPTH+1))'(DEPTH)); // R5

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (q_run && fill == ($clog2(DEPTH+1))'(DEPTH) && !pop_evt) |=> fill == ($clog2(DEPTH+1))'(DEPTH)); // R5

  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    shf_load |-> shf_idle); // R3

  AST_GAP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && gap_cfg != '0) |=> !pop_evt); // R6

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (q_run && !baud_tick && !gap_done) |=> !pop_evt); // R7

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !q_run |=> fill == '0); // R8

  AST_IRQ_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    !q_en |-> !irq); // R9

  AST_PUSHPOP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (q_run && push_evt && pop_evt) |=> fill == $past(fill)); // R10
endmodule

bind txq_pacer txq_pacer_chk #(.DEPTH(DEPTH), .GW(GW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .q_en      (q_en),
  .q_run     (q_run),
  .baud_tick (baud_tick),
  .shf_idle  (shf_idle),
  .shf_load  (shf_load),
  .irq       (irq),
  .fill      (fill),
  .gap_cfg   (gap_cfg),
  .push_evt  (push_evt),
  .pop_evt   (pop_evt),
  .gap_done  (gap_done)
);

// File: tb/txq_pacer_test.sv
`timescale 1ns/1ps
module txq_pacer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       q_en = 1'b0, q_run = 1'b0;
  logic [7:0] gap_cfg = '0;
  logic [4:0] trig_lvl = '0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic       baud_tick = 1'b0, shf_idle = 1'b0;
  logic       shf_load;
  logic [7:0] shf_data;
  logic [4:0] fill;
  logic       irq;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  logic [7:0] ld_d [0:127];
  int         ld_c [0:127];
  int         ld_n = 0;

  txq_pacer uut (
    .clk(clk), .rst_n(rst_n), .q_en(q_en), .q_run(q_run), .gap_cfg(gap_cfg),
    .trig_lvl(trig_lvl), .wr_stb(wr_stb), .wr_data(wr_data), .baud_tick(baud_tick),
    .shf_idle(shf_idle), .shf_load(shf_load), .shf_data(shf_data), .fill(fill), .irq(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  // load monitor, samples 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    if (rst_n && shf_load && ld_n < 128) begin
      ld_d[ld_n] = shf_data;
      ld_c[ld_n] = cyc;
      ld_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_stb = 1'b1; wr_data = v;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic wait_empty();
    for (int k = 0; k < 3000 && fill != 0; k++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // pacing run: queue 4 words behind a frozen counter, then tick every cycle
  task automatic run_gap(input int d, input logic [7:0] base);
    @(negedge clk); gap_cfg = 8'd255; baud_tick = 1'b1; shf_idle = 1'b1;
    repeat (260) @(negedge clk);
    baud_tick = 1'b0; ld_n = 0;
    for (int i = 0; i < 5; i++) begin
      wr(base + 8'(i));
      @(negedge clk);
    end
    repeat (20) @(negedge clk);
    #1;
    chk(fill == 4, "R7 fill frozen", fill, 4);
    chk(ld_n == 1, "R7 single load", ld_n, 1);
    @(negedge clk); gap_cfg = 8'(d); baud_tick = 1'b1;
    wait_empty();
    #1;
    chk(ld_n == 5, "R6 load count", ld_n, 5);
    for (int j = 1; j < 5; j++)
      chk(ld_d[j] == base + 8'(j), "R4 order", ld_d[j], base + j);
    for (int j = 2; j < 5; j++)
      chk(ld_c[j] - ld_c[j-1] == d + 1, "R6 spacing", ld_c[j] - ld_c[j-1], d + 1);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(fill == 0, "R1 fill", fill, 0);
    chk(shf_load == 0, "R1 load", shf_load, 0);
    chk(irq == 0, "R1 irq", irq, 0);

    // R2: direct path
    wr(8'hA5);
    #1;
    chk(shf_load == 0, "R2 held while busy", shf_load, 0);
    @(negedge clk); shf_idle = 1'b1;
    #1;
    chk(shf_load == 1 && shf_data == 8'hA5, "R2 offered", shf_data, 8'hA5);
    @(negedge clk);
    #1;
    chk(shf_load == 0, "R2 offered once", shf_load, 0);

    // R3/R5: fill to capacity behind a frozen gap counter
    @(negedge clk); q_en = 1'b1; q_run = 1'b1; gap_cfg = 8'd255; baud_tick = 1'b0;
    ld_n = 0;
    for (int i = 0; i < 17; i++) begin
      wr(8'h10 + 8'(i));
      @(negedge clk);
    end
    #1;
    chk(fill == 16, "R3 fill count", fill, 16);
    chk(ld_n == 1 && ld_d[0] == 8'h10, "R4 first head", ld_d[0], 8'h10);
    wr(8'hEE);
    repeat (2) @(negedge clk);
    #1;
    chk(fill == 16, "R5 full drop", fill, 16);

    // R9: sweep threshold at fill 16
    for (int l = 0; l < 32; l++) begin
      @(negedge clk); trig_lvl = 5'(l);
      #1;
      chk(irq == (l >= 16), "R9 sweep full", irq, (l >= 16));
    end
    @(negedge clk); q_en = 1'b0;
    #1;
    chk(irq == 0, "R9 bypass", irq, 0);
    @(negedge clk); q_en = 1'b1; trig_lvl = '0;

    // R6 gap 0: drain 16 words
    @(negedge clk); gap_cfg = 8'd0; baud_tick = 1'b1; ld_n = 0;
    wait_empty();
    #1;
    chk(ld_n == 16, "R6 drain count", ld_n, 16);
    for (int j = 0; j < 16; j++)
      chk(ld_d[j] == 8'h11 + 8'(j), "R4 drain order", ld_d[j], 8'h11 + j);
    for (int j = 1; j < 16; j++)
      chk(ld_c[j] - ld_c[j-1] == 1, "R6 gap0 spacing", ld_c[j] - ld_c[j-1], 1);

    run_gap(1, 8'h40);
    run_gap(255, 8'h60);

    // R10: same-cycle push and pop
    @(negedge clk); gap_cfg = 8'd255; baud_tick = 1'b1; shf_idle = 1'b1;
    repeat (260) @(negedge clk);
    baud_tick = 1'b0; ld_n = 0;
    wr(8'h31); @(negedge clk);
    wr(8'h32); @(negedge clk);
    wr(8'h33); @(negedge clk);
    shf_idle = 1'b0; baud_tick = 1'b1;
    repeat (300) @(negedge clk);
    baud_tick = 1'b0;
    wr(8'h99);
    repeat (2) @(negedge clk);
    #1;
    chk(fill == 2, "R3 no move while busy", fill, 2);
    @(negedge clk); shf_idle = 1'b1;
    #1;
    chk(shf_load == 1 && shf_data == 8'h32, "R10 head out", shf_data, 8'h32);
    @(negedge clk); shf_idle = 1'b0;
    #1;
    chk(fill == 2, "R10 fill kept", fill, 2);
    @(negedge clk); gap_cfg = 8'd0; baud_tick = 1'b1; shf_idle = 1'b1; ld_n = 0;
    wait_empty();
    #1;
    chk(ld_n == 2 && ld_d[0] == 8'h33, "R10 next word", ld_d[0], 8'h33);
    chk(ld_d[1] == 8'h99, "R10 pushed word", ld_d[1], 8'h99);

    // R8: clear and resume
    @(negedge clk); gap_cfg = 8'd255; baud_tick = 1'b0;
    wr(8'h51); @(negedge clk);
    wr(8'h52); @(negedge clk);
    wr(8'h53); @(negedge clk);
    #1;
    chk(fill == 2, "R8 before clear", fill, 2);
    @(negedge clk); q_run = 1'b0;
    @(negedge clk); q_run = 1'b1;
    #1;
    chk(fill == 0, "R8 cleared", fill, 0);
    chk(irq == 1, "R9 level 0 at empty", irq, 1);
    ld_n = 0;
    wr(8'h42);
    repeat (2) @(negedge clk);
    #1;
    chk(ld_n == 1 && ld_d[0] == 8'h42, "R8 resume", ld_d[0], 8'h42);
    chk(fill == 0, "R8 empty after", fill, 0);

    for (int l = 0; l < 32; l++) begin
      @(negedge clk); trig_lvl = 5'(l);
      #1;
      chk(irq == 1, "R9 sweep empty", irq, 1);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule